// File: doc/BRIEF.md
# Secondary Scan Path Selector

This block is one device in a primary boundary-scan chain. It runs its own standard test access port state machine and uses it to load an instruction register and two data registers. Through these registers a test controller can splice any one of four secondary scan paths into the primary chain, or leave all four out. Each secondary path has its own mode-select output. The selected output carries the live mode-select level. Every other output is parked at a static level that software chooses separately for each path.

The test clock is forwarded to the secondary paths unchanged. Serial data leaves the device register on the secondary data output and comes back on the secondary data input. When a path is spliced in, that returning data feeds the primary data output. A secondary reset output can be driven from the test reset pin or from a control bit. An active-low error output reports a malformed path selection while the state machine sits in Pause-DR. A condition output with programmable polarity flags any invalid instruction or selection.

Top module: `scan_path_sel`

## Requirements
- R1: While `trst_n` is low, and after it rises, the registers hold their power-up values. The instruction is bypass, no path is selected, all four `sec_tms` outputs are parked high, `err_n` is 1 and `cond` is 1.
- R2: The select register is 8 bits. Bits [1:0] are the path index and bit 2 enables splicing. Bit 3 must be 0. Bit 4+i is the static level of `sec_tms[i]`. When the selection is enabled and valid, `sec_tms[index]` follows the active mode-select source combinationally and every other output shows its static level. With bit 2 clear, all four outputs show their static levels.
- R3: A selection loaded by a DR scan reaches the outputs only at the falling edge of the clock in Update-DR. Up to Exit1-DR the old routing holds.
- R4: A select value with bit 3 set is invalid. No path follows mode-select and all outputs show bits 7:4. `err_n` is low exactly while the state machine is in Pause-DR and an invalid selection is active. It updates on falling edges.
- R5: With a valid path spliced in, the path from `tdi` to `tdo` is the device data register, then one retiming stage, then the secondary path. With no path spliced in, `tdo` comes from the device register alone. A 1-bit bypass scan with a zero-length secondary path therefore shows one extra clock of delay.
- R6: The control register is 4 bits. Bit 0 sets `cond` active-high, bit 1 enables error reporting, bit 2 forces secondary reset and bit 3 routes `alt_tms` in place of `tms`. `sec_trst_n` is low whenever `trst_n` is low or bit 2 is set.
- R7: When reporting is enabled and the instruction or the selection is invalid, `cond` is asserted at the programmed polarity. Otherwise it sits at the inactive level. The reset polarity is active low.
- R8: With control bit 3 set, the spliced output follows `alt_tms` and ignores `tms`.
- R9: Five consecutive clocks with `tms` high reach Test-Logic-Reset, and there the instruction, select and control registers return to their power-up values.
- R10: `sec_tck` equals `tck`. The instruction codes are 3'b111 for bypass, 3'b001 for the select register and 3'b010 for the control register. Any other code is invalid and acts as bypass. The instruction register captures 3'b001, shifted out LSB first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Test reset, active low |
| tms | input | 1 | Primary mode select |
| alt_tms | input | 1 | Alternate mode-select source for the spliced path |
| tdi | input | 1 | Primary serial data in |
| tdo | output | 1 | Primary serial data out |
| sec_tck | output | 1 | Forwarded test clock |
| sec_tms | output | 4 | Per-path mode select |
| sec_tdo | output | 1 | Serial data toward the secondary paths |
| sec_tdi | input | 1 | Serial data returning from the spliced path |
| sec_trst_n | output | 1 | Secondary reset, active low |
| err_n | output | 1 | Invalid-selection flag during Pause-DR, active low |
| cond | output | 1 | Invalid-register condition, programmable polarity |

## Verification
The hardest situation to reach is the Pause-DR error. The flag reflects the selection that is already active, not the one being shifted. The first scan that loads a malformed value must therefore show `err_n` high in its own pause. Only a second DR scan, parked in Pause-DR, shows it low. It must then return high in Exit2-DR. The stimulus also distinguishes a parked output from a following one by choosing static levels opposite to the live mode-select value. The extra retiming stage is exposed by looping `sec_tdo` straight back to `sec_tdi` and comparing bypass scans with and without a path spliced in.

// File: rtl/scan_sel_pkg.sv
`timescale 1ns/1ps
package scan_sel_pkg;
  typedef enum logic [3:0] {
    TLR, RTI, SEL_DR, CAP_DR, SH_DR, EX1_DR, PAU_DR, EX2_DR, UPD_DR,
    SEL_IR, CAP_IR, SH_IR, EX1_IR, PAU_IR, EX2_IR, UPD_IR
  } tap_state_t;

  localparam int PATHS   = 4;
  localparam int IDX_W   = $clog2(PATHS);
  localparam int SEL_EN  = IDX_W;
  localparam int SEL_RSV = IDX_W + 1;
  localparam int SEL_LVL = IDX_W + 2;
  localparam int SEL_W   = SEL_LVL + PATHS;

  localparam int CTL_W     = 4;
  localparam int CTL_POL   = 0;
  localparam int CTL_ERREN = 1;
  localparam int CTL_SRST  = 2;
  localparam int CTL_ALT   = 3;

  localparam int IR_W = 3;
  localparam logic [IR_W-1:0] OP_BYPASS  = '1;
  localparam logic [IR_W-1:0] OP_SELECT  = IR_W'(1);
  localparam logic [IR_W-1:0] OP_CONTROL = IR_W'(2);
  localparam logic [IR_W-1:0] IR_CAPTURE = IR_W'(1);

  localparam logic [SEL_W-1:0] SEL_RESET = {{PATHS{1'b1}}, {(SEL_W-PATHS){1'b0}}};
endpackage

// File: rtl/scan_tap_fsm.sv
`timescale 1ns/1ps
module scan_tap_fsm import scan_sel_pkg::*; (
  input  logic       tck,
  input  logic       rst_n,
  input  logic       tms,
  output tap_state_t state
);
  tap_state_t state_d;

  always_comb begin
    state_d = state;
    case (state)
      TLR:     state_d = tms ? TLR    : RTI;
      RTI:     state_d = tms ? SEL_DR : RTI;
      SEL_DR:  state_d = tms ? SEL_IR : CAP_DR;
      CAP_DR:  state_d = tms ? EX1_DR : SH_DR;
      SH_DR:   state_d = tms ? EX1_DR : SH_DR;
      EX1_DR:  state_d = tms ? UPD_DR : PAU_DR;
      PAU_DR:  state_d = tms ? EX2_DR : PAU_DR;
      EX2_DR:  state_d = tms ? UPD_DR : SH_DR;
      UPD_DR:  state_d = tms ? SEL_DR : RTI;
      SEL_IR:  state_d = tms ? TLR    : CAP_IR;
      CAP_IR:  state_d = tms ? EX1_IR : SH_IR;
      SH_IR:   state_d = tms ? EX1_IR : SH_IR;
      EX1_IR:  state_d = tms ? UPD_IR : PAU_IR;
      PAU_IR:  state_d = tms ? EX2_IR : PAU_IR;
      EX2_IR:  state_d = tms ? UPD_IR : SH_IR;
      UPD_IR:  state_d = tms ? SEL_DR : RTI;
      default: state_d = TLR;
    endcase
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) state <= TLR;
    else        state <= state_d;
  end

  // checker: count consecutive mode-select highs
  logic [2:0] hi_cnt;
  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n)               hi_cnt <= '0;
    else if (!tms)            hi_cnt <= '0;
    else if (hi_cnt != 3'd4)  hi_cnt <= hi_cnt + 3'd1;
  end

  assert_five_high_R9: assert property (@(posedge tck) disable iff (!rst_n)
    (tms && hi_cnt == 3'd4) |=> state == TLR);
endmodule

// File: rtl/scan_sel_regs.sv
`timescale 1ns/1ps
module scan_sel_regs import scan_sel_pkg::*; (
  input  logic             tck,
  input  logic             rst_n,
  input  logic             tdi,
  input  tap_state_t       state,
  output logic [IR_W-1:0]  ir_q,
  output logic [SEL_W-1:0] sel_q,
  output logic [CTL_W-1:0] ctl_q,
  output logic             ir_bad,
  output logic             dev_so
);
  logic [IR_W-1:0]  ir_sr, ir_sr_d, ir_d;
  logic [SEL_W-1:0] sel_sr, sel_sr_d, sel_d;
  logic [CTL_W-1:0] ctl_sr, ctl_sr_d, ctl_d;
  logic             byp_q, byp_d;
  logic             pick_sel, pick_ctl, in_ir_col;

  assign pick_sel  = (ir_q == OP_SELECT);
  assign pick_ctl  = (ir_q == OP_CONTROL);
  assign ir_bad    = !(pick_sel || pick_ctl || ir_q == OP_BYPASS);
  assign in_ir_col = state inside {CAP_IR, SH_IR, EX1_IR, PAU_IR, EX2_IR, UPD_IR};

  // shift stages: next state
  always_comb begin
    ir_sr_d  = ir_sr;
    sel_sr_d = sel_sr;
    ctl_sr_d = ctl_sr;
    byp_d    = byp_q;
    case (state)
      CAP_IR: ir_sr_d = IR_CAPTURE;
      SH_IR:  ir_sr_d = {tdi, ir_sr[IR_W-1:1]};
      CAP_DR: begin
        byp_d = 1'b0;
        if (pick_sel) sel_sr_d = sel_q;
        if (pick_ctl) ctl_sr_d = ctl_q;
      end
      SH_DR: begin
        byp_d = tdi;
        if (pick_sel) sel_sr_d = {tdi, sel_sr[SEL_W-1:1]};
        if (pick_ctl) ctl_sr_d = {tdi, ctl_sr[CTL_W-1:1]};
      end
      default: ;
    endcase
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) begin
      ir_sr  <= IR_CAPTURE;
      sel_sr <= '0;
      ctl_sr <= '0;
      byp_q  <= 1'b0;
    end else begin
      ir_sr  <= ir_sr_d;
      sel_sr <= sel_sr_d;
      ctl_sr <= ctl_sr_d;
      byp_q  <= byp_d;
    end
  end

  // update stages: next state, applied on the falling edge
  always_comb begin
    ir_d  = ir_q;
    sel_d = sel_q;
    ctl_d = ctl_q;
    if (state == TLR) begin
      ir_d  = OP_BYPASS;
      sel_d = SEL_RESET;
      ctl_d = '0;
    end else if (state == UPD_IR) begin
      ir_d = ir_sr;
    end else if (state == UPD_DR) begin
      if (pick_sel) sel_d = sel_sr;
      if (pick_ctl) ctl_d = ctl_sr;
    end
  end

  always_ff @(negedge tck or negedge rst_n) begin
    if (!rst_n) begin
      ir_q  <= OP_BYPASS;
      sel_q <= SEL_RESET;
      ctl_q <= '0;
    end else begin
      ir_q  <= ir_d;
      sel_q <= sel_d;
      ctl_q <= ctl_d;
    end
  end

  always_comb begin
    if (in_ir_col)     dev_so = ir_sr[0];
    else if (pick_sel) dev_so = sel_sr[0];
    else if (pick_ctl) dev_so = ctl_sr[0];
    else               dev_so = byp_q;
  end

  assert_sel_hold_R3: assert property (@(posedge tck) disable iff (!rst_n)
    !$stable(sel_q) |-> (state == UPD_DR || state == TLR));

  assert_ir_hold_R10: assert property (@(posedge tck) disable iff (!rst_n)
    !$stable(ir_q) |-> (state == UPD_IR || state == TLR));
endmodule

// File: rtl/scan_sel_route.sv
`timescale 1ns/1ps
module scan_sel_route import scan_sel_pkg::*; (
  input  logic             tck,
  input  logic             rst_n,
  input  tap_state_t       state,
  input  logic             tms,
  input  logic             alt_tms,
  input  logic [SEL_W-1:0] sel_q,
  input  logic [CTL_W-1:0] ctl_q,
  input  logic             ir_bad,
  input  logic             dev_so,
  input  logic             sec_tdi,
  output logic [PATHS-1:0] sec_tms,
  output logic             sec_tdo,
  output logic             tdo,
  output logic             err_n,
  output logic             cond
);
  logic             route_on, sel_bad, src, flag;
  logic [IDX_W-1:0] idx;
  logic [PATHS-1:0] lvl;
  logic             ret_q;
  logic             tdo_d, err_d, cond_d;

  assign sel_bad  = sel_q[SEL_RSV];
  assign route_on = sel_q[SEL_EN] & ~sel_bad;
  assign idx      = sel_q[IDX_W-1:0];
  assign lvl      = sel_q[SEL_LVL +: PATHS];
  assign src      = ctl_q[CTL_ALT] ? alt_tms : tms;

  for (genvar p = 0; p < PATHS; p++) begin : g_path
    assign sec_tms[p] = (route_on && idx == IDX_W'(p)) ? src : lvl[p];
  end

  // retiming stage for data returning from the spliced path
  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) ret_q <= 1'b0;
    else        ret_q <= sec_tdi;
  end

  assign flag   = ctl_q[CTL_ERREN] & (ir_bad | sel_bad);
  assign tdo_d  = route_on ? ret_q : dev_so;
  assign err_d  = ~(state == PAU_DR && sel_bad);
  assign cond_d = ctl_q[CTL_POL] ? flag : ~flag;

  always_ff @(negedge tck or negedge rst_n) begin
    if (!rst_n) begin
      tdo     <= 1'b0;
      sec_tdo <= 1'b0;
      err_n   <= 1'b1;
      cond    <= 1'b1;
    end else begin
      tdo     <= tdo_d;
      sec_tdo <= dev_so;
      err_n   <= err_d;
      cond    <= cond_d;
    end
  end

  assert_one_follows_R2: assert property (@(posedge tck) disable iff (!rst_n)
    $countones(sec_tms ^ lvl) <= 1);

  assert_err_in_pause_R4: assert property (@(posedge tck) disable iff (!rst_n)
    !err_n |-> (state == PAU_DR && sel_bad));

  assert_cond_quiet_R7: assert property (@(posedge tck) disable iff (!rst_n)
    (!ctl_q[CTL_ERREN] && $stable(ctl_q)) |-> (cond == !ctl_q[CTL_POL]));
endmodule

// File: rtl/scan_path_sel.sv
`timescale 1ns/1ps
module scan_path_sel import scan_sel_pkg::*; (
  input  logic             tck,
  input  logic             trst_n,
  input  logic             tms,
  input  logic             alt_tms,
  input  logic             tdi,
  output logic             tdo,
  output logic             sec_tck,
  output logic [PATHS-1:0] sec_tms,
  output logic             sec_tdo,
  input  logic             sec_tdi,
  output logic             sec_trst_n,
  output logic             err_n,
  output logic             cond
);
  logic [1:0]       rs_q;
  logic             rst_n;
  tap_state_t       state;
  logic [IR_W-1:0]  ir_q;
  logic [SEL_W-1:0] sel_q;
  logic [CTL_W-1:0] ctl_q;
  logic             ir_bad, dev_so;

  // reset asserts at once, releases after two rising edges
  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) rs_q <= '0;
    else         rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_n = rs_q[1];

  assign sec_tck    = tck;
  assign sec_trst_n = trst_n & ~ctl_q[CTL_SRST];

  scan_tap_fsm u_fsm (
    .tck   (tck),
    .rst_n (rst_n),
    .tms   (tms),
    .state (state)
  );

  scan_sel_regs u_regs (
    .tck    (tck),
    .rst_n  (rst_n),
    .tdi    (tdi),
    .state  (state),
    .ir_q   (ir_q),
    .sel_q  (sel_q),
    .ctl_q  (ctl_q),
    .ir_bad (ir_bad),
    .dev_so (dev_so)
  );

  scan_sel_route u_route (
    .tck     (tck),
    .rst_n   (rst_n),
    .state   (state),
    .tms     (tms),
    .alt_tms (alt_tms),
    .sel_q   (sel_q),
    .ctl_q   (ctl_q),
    .ir_bad  (ir_bad),
    .dev_so  (dev_so),
    .sec_tdi (sec_tdi),
    .sec_tms (sec_tms),
    .sec_tdo (sec_tdo),
    .tdo     (tdo),
    .err_n   (err_n),
    .cond    (cond)
  );

  assert_sec_reset_R6: assert property (@(posedge tck) disable iff (!rst_n)
    (ctl_q[CTL_SRST] && $stable(ctl_q)) |-> !sec_trst_n);
endmodule

// File: tb/scan_path_sel_test.sv
`timescale 1ns/1ps
module scan_path_sel_test;
  logic       tck = 1'b0;
  logic       trst_n, tms, alt_tms, tdi;
  logic       tdo, sec_tck, sec_tdo, sec_tdi, sec_trst_n, err_n, cond;
  logic [3:0] sec_tms;
  int total = 0;
  int bad   = 0;

  typedef struct { logic v; string tag; } exp_t;
  exp_t exp_q[$];

  always #2.5 tck = ~tck;
  assign sec_tdi = sec_tdo;  // zero-length secondary path

  scan_path_sel uut (
    .tck(tck), .trst_n(trst_n), .tms(tms), .alt_tms(alt_tms), .tdi(tdi), .tdo(tdo),
    .sec_tck(sec_tck), .sec_tms(sec_tms), .sec_tdo(sec_tdo), .sec_tdi(sec_tdi),
    .sec_trst_n(sec_trst_n), .err_n(err_n), .cond(cond)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops one expected tdo bit after each falling edge
  always @(negedge tck) begin
    exp_t e;
    #0.5;
    if (exp_q.size() != 0) begin
      e = exp_q.pop_front();
      chk(e.tag, {7'd0, tdo}, {7'd0, e.v});
    end
  end

  task automatic step(input logic m, input logic d);
    tms = m; tdi = d;
    @(negedge tck); #1;
  endtask

  task automatic load_ir(input logic [2:0] code);
    step(1,0); step(1,0); step(0,0); step(0,0);
    for (int i = 0; i < 3; i++) step(i == 2, code[i]);
    step(1,0); step(0,0);
  endtask

  task automatic dr_head();
    step(1,0); step(0,0); step(0,0);
  endtask

  task automatic dr_body(input logic [7:0] val, input int w);
    for (int i = 0; i < w; i++) step(i == w-1, val[i]);
  endtask

  task automatic dr_tail();
    step(1,0); step(0,0);
  endtask

  task automatic dr_tail_pause(input logic exp_err, input string tag);
    step(0,0);
    chk({tag, " err in pause"}, {7'd0, err_n}, {7'd0, exp_err});
    step(1,0);
    chk({tag, " err after pause"}, {7'd0, err_n}, 8'd1);
    step(1,0); step(0,0);
  endtask

  task automatic load_dr(input logic [7:0] val, input int w);
    dr_head(); dr_body(val, w); dr_tail();
  endtask

  // bypass scan, scoreboard-checked; lag is 0 (no path) or 1 (spliced)
  task automatic bypass_scan(input logic [15:0] pat, input int lag, input string tag);
    dr_head();
    for (int j = 0; j < 16; j++) begin
      exp_t e;
      e.tag = tag;
      e.v   = (lag == 0) ? pat[j] : ((j == 0) ? 1'b0 : pat[j-1]);
      exp_q.push_back(e);
      step(j == 15, pat[j]);
    end
    dr_tail();
  endtask

  task automatic follow_chk(input logic m, input logic [3:0] exp, input string tag);
    tms = m; #0.2;
    chk(tag, {4'd0, sec_tms}, {4'd0, exp});
    tms = 1'b0; #0.2;
  endtask

  initial begin
    #(5.0 * 150000);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    trst_n = 1'b0; tms = 1'b1; tdi = 1'b0; alt_tms = 1'b0;
    repeat (3) @(negedge tck);
    #1;
    chk("R1 tms parked high in reset", {4'd0, sec_tms}, 8'h0F);
    chk("R1 err_n in reset", {7'd0, err_n}, 8'd1);
    chk("R1 cond in reset", {7'd0, cond}, 8'd1);
    chk("R6 sec reset follows trst", {7'd0, sec_trst_n}, 8'd0);
    trst_n = 1'b1;
    step(1,0); step(1,0); step(1,0);
    chk("R6 sec reset released", {7'd0, sec_trst_n}, 8'd1);
    chk("R1 tms parked after release", {4'd0, sec_tms}, 8'h0F);
    step(0,0);
    chk("R10 clock low", {7'd0, sec_tck}, {7'd0, tck});
    #2.5;
    chk("R10 clock high", {7'd0, sec_tck}, {7'd0, tck});
    @(negedge tck); #1;

    // R10: instruction capture pattern, shifted LSB first, no path spliced
    step(1,0); step(1,0); step(0,0);
    begin
      exp_t e;
      e.tag = "R10 ir capture"; e.v = 1'b1; exp_q.push_back(e); step(0,0);
      e.v = 1'b0; exp_q.push_back(e); step(0,1);
      e.v = 1'b0; exp_q.push_back(e); step(0,1);
      e.v = 1'b1; exp_q.push_back(e); step(1,1);
    end
    step(1,0); step(0,0);

    bypass_scan(16'hA5C3, 0, "R5 bypass without path");

    // R2/R3: select path 2, static levels 0100
    load_ir(3'b001);
    dr_head(); dr_body(8'h46, 8);
    chk("R3 routing held before update", {4'd0, sec_tms}, 8'h0F);
    step(1,0);
    chk("R3 routing at update", {4'd0, sec_tms}, 8'h04);
    step(0,0);
    chk("R2 path2 follows tms low", {4'd0, sec_tms}, 8'h00);
    follow_chk(1'b1, 4'b0100, "R2 path2 follows tms high");

    load_dr(8'h14, 8);
    chk("R2 path0 follows tms low", {4'd0, sec_tms}, 8'h00);
    load_dr(8'h87, 8);
    chk("R2 path3 follows tms low", {4'd0, sec_tms}, 8'h00);
    load_dr(8'hA0, 8);
    chk("R2 none selected tms low", {4'd0, sec_tms}, 8'h0A);
    follow_chk(1'b1, 4'b1010, "R2 none selected tms high");

    // R5: path 1 spliced, statics 0010
    load_dr(8'h25, 8);
    chk("R2 path1 follows tms low", {4'd0, sec_tms}, 8'h00);
    load_ir(3'b111);
    bypass_scan(16'h3C96, 1, "R5 bypass with path");

    // R4: invalid selection
    load_ir(3'b001);
    dr_head(); dr_body(8'h5E, 8); dr_tail_pause(1'b1, "R4 first scan");
    chk("R4 invalid parks all", {4'd0, sec_tms}, 8'h05);
    follow_chk(1'b1, 4'b0101, "R4 invalid ignores tms");
    dr_head(); dr_body(8'h5E, 8); dr_tail_pause(1'b0, "R4 second scan");

    // R7: condition output
    load_ir(3'b010);
    chk("R7 reporting off", {7'd0, cond}, 8'd1);
    load_dr(8'h02, 4);
    chk("R7 active low asserted", {7'd0, cond}, 8'd0);
    load_dr(8'h03, 4);
    chk("R7 active high asserted", {7'd0, cond}, 8'd1);
    load_ir(3'b001);
    load_dr(8'h25, 8);
    chk("R7 active high idle", {7'd0, cond}, 8'd0);
    load_ir(3'b100);
    chk("R7 invalid instruction", {7'd0, cond}, 8'd1);
    bypass_scan(16'h5AF0, 1, "R10 invalid code acts as bypass");

    // R8: alternate mode-select source
    load_ir(3'b010);
    load_dr(8'h0B, 4);
    alt_tms = 1'b1; #0.2;
    chk("R8 follows alt high", {4'd0, sec_tms}, 8'h02);
    alt_tms = 1'b0; #0.2;
    chk("R8 follows alt low", {4'd0, sec_tms}, 8'h00);
    follow_chk(1'b1, 4'b0000, "R8 tms ignored");

    // R6: control reset bit
    load_dr(8'h0F, 4);
    chk("R6 control forces sec reset", {7'd0, sec_trst_n}, 8'd0);
    load_dr(8'h00, 4);
    chk("R6 control releases sec reset", {7'd0, sec_trst_n}, 8'd1);
    load_dr(8'h0E, 4);

    // R9: reset through five tms highs
    for (int k = 0; k < 5; k++) step(1,0);
    chk("R9 statics back to high", {4'd0, sec_tms}, 8'h0F);
    chk("R9 control cleared", {7'd0, sec_trst_n}, 8'd1);
    step(0,0);
    chk("R9 cond inactive", {7'd0, cond}, 8'd1);

    repeat (2) @(negedge tck);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule